// File: doc/BRIEF.md
# Pulse-Width Up/Down Trim Controller

This block turns a single three-level control line into step commands for a 7-bit trim code. The line is seen through two digitized comparator flags: one for "below mid" and one for "above mid". When neither flag is set, the line is at mid, which is the idle or floating level. An excursion to the low side that lasts long enough raises the code by one. An excursion to the high side lowers it by one. Whether an excursion counts depends on its length, measured in clock cycles of the system clock. The code saturates at both ends. On reset, the code is loaded from a stored-value port, which stands in for the nonvolatile cells. The factory value on that port is half scale (64).

An enable input gates the interface. After enable rises there is a startup window during which the line is ignored. After that, every excursion must be preceded by a minimum quiet time at mid. The first excursion that qualifies after each enable is thrown away on purpose, because power sequencing can produce one false pulse. A separate write-cycle detector can report a programming ramp on the same wire. While it does, decoding stops and any pulse in progress is dropped. Time constants are given in microseconds and scaled by the clock rate in kHz.

Top module: `trim_pulse_ctrl`

## Requirements
- R1: While reset is asserted, `trimCode` takes the value of `presetCode`, and that value holds after reset is released.
- R2: A low excursion (`lineLow`=1, `lineHigh`=0) sampled on more than `HOLD_US` worth of consecutive cycles raises `trimCode` by exactly one. The change comes after the line returns to mid. An excursion of exactly `HOLD_US` worth of cycles causes no change.
- R3: A high excursion (`lineHigh`=1, `lineLow`=0) longer than `HOLD_US` worth of cycles lowers `trimCode` by exactly one after the line returns to mid.
- R4: An excursion shorter than `HOLD_US` worth of cycles leaves `trimCode` unchanged. This covers runts below `RUNT_US` and marginal pulses between the two limits.
- R5: After each rising edge of `enable` (and after reset), the first excursion that would otherwise qualify is discarded. Later excursions act normally.
- R6: While `enable` is low, the line has no effect on `trimCode`.
- R7: For `WAKE_US` worth of cycles after `enable` rises, excursions are ignored. They also do not use up the first-pulse discard.
- R8: An excursion that begins before the line has been at mid for `SPACE_US` worth of cycles is ignored. This applies after startup, after a previous excursion, and after a programming ramp.
- R9: `trimCode` saturates. An increment at 127 and a decrement at 0 leave it unchanged.
- R10: While `progRamp` is high, no step is applied, and any excursion in progress is discarded.
- R11: While a qualifying excursion is still being held away from mid, `trimCode` does not change.
- R12: An excursion that switches directly from one side to the other without passing through mid is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset; loads the preset code |
| enable | input | 1 | Interface enable; low makes the line ignored |
| lineLow | input | 1 | Comparator flag: control line below mid |
| lineHigh | input | 1 | Comparator flag: control line above mid |
| progRamp | input | 1 | Write-cycle detector reports a programming ramp |
| presetCode | input | CODE_W | Stored code loaded at reset |
| trimCode | output | CODE_W | Current trim code |

## Verification
The bench drives excursions of chosen lengths on either side of mid. The lengths include the runt limit, just below and just above the hold limit, and lengths well beyond it. This shows apart the three pulse classes and the two directions.

Sequences that vary the timing target the other rules:
- a pulse during startup, followed by two valid pulses, separates startup blocking from the first-pulse discard;
- a short mid gap before a pulse exercises the spacing rule;
- a direct side swap exercises R12;
- a ramp inside a pulse exercises R10;
- a check taken while a long pulse is still held exercises R11.

Presets near 0 and 127 drive the code into saturation. A seeded random run of mixed lengths and directions is compared with a reference step model.

// File: rtl/trim_pkg.sv
package trim_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_WAKE,
    ST_QUIET,
    ST_READY,
    ST_MEASURE
  } trimState_t;

  typedef struct packed {
    logic stepUp;
    logic stepDown;
  } trimStrobe_t;

endpackage

// File: rtl/trim_pulse_fsm.sv
module trim_pulse_fsm
  import trim_pkg::*;
#(
  parameter int RUNT_CYC  = 20,
  parameter int HOLD_CYC  = 200,
  parameter int SPACE_CYC = 10,
  parameter int WAKE_CYC  = 1000,
  parameter int CNT_W     = 11
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        lineLow,
  input  logic        lineHigh,
  input  logic        progRamp,
  output trimStrobe_t strobe
);

  localparam logic [CNT_W-1:0] CNT_CAP   = CNT_W'(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] WAKE_LAST  = CNT_W'(WAKE_CYC - 1);
  localparam logic [CNT_W-1:0] SPACE_LAST = CNT_W'(SPACE_CYC - 1);

  trimState_t       state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             sideLow, sideLowNext;
  logic             firstPend, firstPendNext;
  trimStrobe_t      strobeNext;

  logic awayLow, awayHigh, atMid, sameSide, qualified;

  // Conflicting flags are read as mid.
  assign awayLow   = lineLow & ~lineHigh;
  assign awayHigh  = lineHigh & ~lineLow;
  assign atMid     = ~(awayLow | awayHigh);
  assign sameSide  = sideLow ? awayLow : awayHigh;
  // The runt guard also holds if the hold limit is set below the runt limit.
  assign qualified = (cnt >= CNT_W'(RUNT_CYC)) && (cnt > CNT_W'(HOLD_CYC));

  always_comb begin
    stateNext     = state;
    cntNext       = cnt;
    sideLowNext   = sideLow;
    firstPendNext = firstPend;
    strobeNext    = '0;
    if (!enable) begin
      stateNext     = ST_OFF;
      cntNext       = '0;
      firstPendNext = 1'b1;
    end else begin
      unique case (state)
        ST_OFF: begin
          stateNext = ST_WAKE;
          cntNext   = '0;
        end
        ST_WAKE: begin
          if (cnt == WAKE_LAST) begin
            stateNext = ST_QUIET;
            cntNext   = '0;
          end else begin
            cntNext = cnt + 1'b1;
          end
        end
        default: begin
          if (progRamp) begin
            stateNext = ST_QUIET;
            cntNext   = '0;
          end else begin
            unique case (state)
              ST_QUIET: begin
                if (!atMid) begin
                  cntNext = '0;
                end else if (cnt == SPACE_LAST) begin
                  stateNext = ST_READY;
                  cntNext   = '0;
                end else begin
                  cntNext = cnt + 1'b1;
                end
              end
              ST_READY: begin
                if (!atMid) begin
                  stateNext   = ST_MEASURE;
                  sideLowNext = awayLow;
                  cntNext     = CNT_W'(1);
                end
              end
              default: begin
                if (sameSide) begin
                  cntNext = (cnt == CNT_CAP) ? cnt : cnt + 1'b1;
                end else begin
                  stateNext = ST_QUIET;
                  cntNext   = '0;
                  if (atMid && qualified) begin
                    if (firstPend) begin
                      firstPendNext = 1'b0;
                    end else begin
                      strobeNext.stepUp   = sideLow;
                      strobeNext.stepDown = ~sideLow;
                    end
                  end
                end
              end
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_OFF;
      cnt       <= '0;
      sideLow   <= 1'b0;
      firstPend <= 1'b1;
      strobe    <= '0;
    end else begin
      state     <= stateNext;
      cnt       <= cntNext;
      sideLow   <= sideLowNext;
      firstPend <= firstPendNext;
      strobe    <= strobeNext;
    end
  end

endmodule

// File: rtl/trim_code_reg.sv
module trim_code_reg
  import trim_pkg::*;
#(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] presetCode,
  input  trimStrobe_t       strobe,
  output logic [CODE_W-1:0] code
);

  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic [CODE_W-1:0] CODE_MIN = '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      code <= presetCode;
    end else if (strobe.stepUp && code != CODE_MAX) begin
      code <= code + 1'b1;
    end else if (strobe.stepDown && code != CODE_MIN) begin
      code <= code - 1'b1;
    end
  end

endmodule

// File: rtl/trim_pulse_ctrl.sv
module trim_pulse_ctrl
  import trim_pkg::*;
#(
  parameter int CODE_W   = 7,
  parameter int CLK_KHZ  = 125000,
  parameter int RUNT_US  = 20,
  parameter int HOLD_US  = 200,
  parameter int SPACE_US = 10,
  parameter int WAKE_US  = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              lineLow,
  input  logic              lineHigh,
  input  logic              progRamp,
  input  logic [CODE_W-1:0] presetCode,
  output logic [CODE_W-1:0] trimCode
);

  localparam int RUNT_CYC  = (CLK_KHZ * RUNT_US) / 1000;
  localparam int HOLD_CYC  = (CLK_KHZ * HOLD_US) / 1000;
  localparam int SPACE_CYC = (CLK_KHZ * SPACE_US) / 1000;
  localparam int WAKE_CYC  = (CLK_KHZ * WAKE_US) / 1000;
  localparam int CNT_TOP   = (WAKE_CYC > HOLD_CYC + 2) ? WAKE_CYC : HOLD_CYC + 2;
  localparam int CNT_W     = $clog2(CNT_TOP + 1);

  trimStrobe_t strobe;

  trim_pulse_fsm #(
    .RUNT_CYC (RUNT_CYC),
    .HOLD_CYC (HOLD_CYC),
    .SPACE_CYC(SPACE_CYC),
    .WAKE_CYC (WAKE_CYC),
    .CNT_W    (CNT_W)
  ) u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .lineLow (lineLow),
    .lineHigh(lineHigh),
    .progRamp(progRamp),
    .strobe  (strobe)
  );

  trim_code_reg #(
    .CODE_W(CODE_W)
  ) u_code (
    .clk       (clk),
    .rstN      (rstN),
    .presetCode(presetCode),
    .strobe    (strobe),
    .code      (trimCode)
  );

endmodule

// File: rtl/trim_pulse_ctrl_chk.sv
module trim_pulse_ctrl_chk #(
  parameter int CODE_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              progRamp,
  input logic [CODE_W-1:0] trimCode,
  input logic              stepUp,
  input logic              stepDown
);

  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic [CODE_W-1:0] CODE_MIN = '0;

  // R2 R3
  one_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trimCode != $past(trimCode)) |->
      (trimCode == $past(trimCode) + 1'b1 || trimCode == $past(trimCode) - 1'b1));

  // R2 R3
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stepUp, stepDown}));

  // R6
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> $stable(trimCode));

  // R10
  ramp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    progRamp |=> $stable(trimCode));

  // R9
  no_wrap_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(trimCode) == CODE_MAX) |-> (trimCode != CODE_MIN));

  // R9
  no_wrap_bottom_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(trimCode) == CODE_MIN) |-> (trimCode != CODE_MAX));

endmodule

bind trim_pulse_ctrl trim_pulse_ctrl_chk #(
  .CODE_W(CODE_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .enable  (enable),
  .progRamp(progRamp),
  .trimCode(trimCode),
  .stepUp  (strobe.stepUp),
  .stepDown(strobe.stepDown)
);

// File: tb/trim_pulse_ctrl_tb.sv
module trim_pulse_ctrl_tb;

  localparam int CODE_W  = 7;
  localparam int HOLD    = 200;
  localparam int WAKE    = 1000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              enable = 1'b0;
  logic              lineLow = 1'b0;
  logic              lineHigh = 1'b0;
  logic              progRamp = 1'b0;
  logic [CODE_W-1:0] presetCode = 7'd64;
  logic [CODE_W-1:0] trimCode;

  int checks = 0;
  int failures = 0;
  logic finished = 1'b0;
  logic [CODE_W-1:0] expCode;

  always #4 clk = ~clk;

  // Time scaled so one clock cycle stands for one microsecond.
  trim_pulse_ctrl #(
    .CODE_W  (CODE_W),
    .CLK_KHZ (1000),
    .RUNT_US (20),
    .HOLD_US (HOLD),
    .SPACE_US(10),
    .WAKE_US (WAKE)
  ) u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .lineLow   (lineLow),
    .lineHigh  (lineHigh),
    .progRamp  (progRamp),
    .presetCode(presetCode),
    .trimCode  (trimCode)
  );

  function automatic logic [CODE_W-1:0] stepModel(logic [CODE_W-1:0] cur, bit isLow, int len);
    if (len <= HOLD) return cur;
    if (isLow) return (cur == 7'd127) ? cur : cur + 7'd1;
    return (cur == 7'd0) ? cur : cur - 7'd1;
  endfunction

  task automatic check(string req, logic [CODE_W-1:0] act, logic [CODE_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: trimCode=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(bit isLow, int len);
    @(negedge clk);
    lineLow  = isLow;
    lineHigh = !isLow;
    repeat (len) @(negedge clk);
    lineLow  = 1'b0;
    lineHigh = 1'b0;
  endtask

  task automatic doReset(logic [CODE_W-1:0] pre);
    @(negedge clk);
    rstN = 1'b0;
    presetCode = pre;
    idle(5);
    rstN = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd2024));
    enable = 1'b1;
    doReset(7'd64);
    idle(1);
    check("R1 reset preset", trimCode, 7'd64);

    // R7: pulse inside the startup window
    idle(50);
    pulse(1'b1, 300);
    check("R7 startup pulse", trimCode, 7'd64);
    idle(WAKE);
    pulse(1'b1, 250);
    idle(20);
    check("R5 first pulse discarded", trimCode, 7'd64);
    pulse(1'b1, 250);
    idle(20);
    check("R2 low raises", trimCode, 7'd65);
    pulse(1'b0, 250);
    idle(20);
    check("R3 high lowers", trimCode, 7'd64);
    pulse(1'b1, HOLD);
    idle(20);
    check("R2 exactly hold no change", trimCode, 7'd64);
    pulse(1'b1, HOLD + 1);
    idle(20);
    check("R2 hold plus one raises", trimCode, 7'd65);
    pulse(1'b1, 19);
    idle(20);
    check("R4 runt low", trimCode, 7'd65);
    pulse(1'b1, 100);
    idle(20);
    check("R4 marginal low", trimCode, 7'd65);
    pulse(1'b0, 20);
    idle(20);
    check("R4 marginal high", trimCode, 7'd65);

    // R11: still held away past the limit
    @(negedge clk);
    lineLow = 1'b1;
    idle(260);
    check("R11 no change while held", trimCode, 7'd65);
    lineLow = 1'b0;
    idle(20);
    check("R11 change after return", trimCode, 7'd66);

    // R12: direct swap
    @(negedge clk);
    lineLow = 1'b1;
    idle(250);
    lineLow = 1'b0;
    lineHigh = 1'b1;
    idle(250);
    lineHigh = 1'b0;
    idle(20);
    check("R12 side swap discarded", trimCode, 7'd66);

    // R8: spacing
    pulse(1'b1, 250);
    idle(3);
    check("R8 prior pulse applied", trimCode, 7'd67);
    pulse(1'b1, 250);
    idle(20);
    check("R8 too close ignored", trimCode, 7'd67);
    pulse(1'b1, 250);
    idle(20);
    check("R8 spaced pulse applied", trimCode, 7'd68);

    // R10: ramp in the middle of a pulse
    @(negedge clk);
    lineLow = 1'b1;
    idle(100);
    progRamp = 1'b1;
    idle(50);
    progRamp = 1'b0;
    idle(150);
    lineLow = 1'b0;
    idle(20);
    check("R10 ramp drops pulse", trimCode, 7'd68);

    // R6: disabled
    enable = 1'b0;
    idle(5);
    pulse(1'b1, 250);
    idle(20);
    pulse(1'b0, 250);
    idle(20);
    check("R6 disabled ignores line", trimCode, 7'd68);
    enable = 1'b1;
    idle(WAKE + 50);
    pulse(1'b0, 250);
    idle(20);
    check("R5 re-enable first discarded", trimCode, 7'd68);
    pulse(1'b0, 250);
    idle(20);
    check("R5 re-enable second applied", trimCode, 7'd67);

    // R9: top saturation
    doReset(7'd126);
    idle(WAKE + 50);
    pulse(1'b1, 250);
    idle(20);
    pulse(1'b1, 250);
    idle(20);
    check("R9 reach top", trimCode, 7'd127);
    pulse(1'b1, 250);
    idle(20);
    check("R9 saturate top", trimCode, 7'd127);

    // R9: bottom saturation
    doReset(7'd1);
    idle(1);
    check("R1 reset preset low", trimCode, 7'd1);
    idle(WAKE + 50);
    pulse(1'b0, 250);
    idle(20);
    pulse(1'b0, 250);
    idle(20);
    check("R9 reach bottom", trimCode, 7'd0);
    pulse(1'b0, 250);
    idle(20);
    check("R9 saturate bottom", trimCode, 7'd0);

    // Random mix: R2 R3 R4 R9
    doReset(7'($urandom_range(0, 127)));
    expCode = presetCode;
    idle(WAKE + 50);
    pulse(1'b1, 250);
    idle(20);
    for (int i = 0; i < 40; i++) begin
      int lens[8] = '{5, 19, 25, 150, 200, 201, 230, 260};
      int len = lens[$urandom_range(0, 7)];
      bit isLow = 1'($urandom_range(0, 1));
      pulse(isLow, len);
      idle(12 + $urandom_range(0, 28));
      expCode = stepModel(expCode, isLow, len);
      check("R2 R3 R4 R9 random", trimCode, expCode);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule